// File: doc/BRIEF.md
# Pause-Width Reader Bit Transmitter

This block sends one reader-to-card frame by switching the RF carrier off and on. Each bit opens with a short carrier-off gap of fixed length. After the gap the carrier stays on for a time that depends on the bit value. A one therefore takes longer on air than a zero. Before each bit is encoded, it is XORed with a keystream bit taken from an external scrambler. The block then pulses a strobe so that the scrambler moves on to its next bit. One more gap after the final bit marks the end of the frame.

All timing is counted in ticks at 1.5 ticks per microsecond, and the block's clock is that tick. A free-running timestamp drives every interval. Each phase ends at a deadline equal to the previous deadline plus the phase length, so rounding never builds up across a frame. The timestamp at which the last frame ended is kept. The next frame may not begin its first gap until a fixed quiet interval has passed since that moment.

Top module: `pause_width_tx`

## Requirements
- R1: While reset is active, and in every cycle with busy low, the modulation output is 0 (carrier on). After reset, busy, done and the keystream advance strobe are all 0.
- R2: Each bit begins with the modulation output at 1 for exactly 30 consecutive cycles.
- R3: Measured from the first cycle of one bit's pause to the first cycle of the next pause, a transmitted 1 lasts exactly 150 cycles and a transmitted 0 lasts exactly 90 cycles.
- R4: When a start is accepted within 330 cycles of the previous frame's end, the carrier stays on for exactly 330 cycles between the last pause of that frame and the first pause of the new frame. This includes a start in the cycle where done is high.
- R5: Bit 0 of the frame word (the LSB) is sent first, followed by the bits in rising index order.
- R6: The transmitted value of bit k is frame bit k XOR the keystream input sampled for that bit. The advance strobe is high for exactly one cycle per transmitted bit, in the first cycle of that bit's pause.
- R7: After the last bit, one closing pause of exactly 30 cycles is sent. Done is high for exactly one cycle: the first cycle after that pause, when the carrier is back on.
- R8: A start request while busy is high has no effect: the frame on air, its bit count and the done count stay those of the accepted frame.
- R9: A length of 0 sends only the closing pause and advances the keystream zero times.
- R10: The length accepts 0 to 32 bits. A length above 32 is treated as 32.
- R11: If at least 330 cycles have already passed since the previous frame's end when start is accepted in cycle c, the first pause begins in cycle c+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, 1.5 ticks per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| frame_i | input | 32 | Frame data word, sampled on an accepted start |
| len_i | input | 6 | Number of bits to send, sampled on an accepted start |
| ks_bit_i | input | 1 | Current keystream bit from the scrambler |
| ks_adv_o | output | 1 | One-cycle pulse: scrambler moves to the next bit |
| mod_o | output | 1 | 1 = carrier off (pause), 0 = carrier on |
| busy_o | output | 1 | A frame is waiting or on air |
| done_o | output | 1 | One-cycle pulse when the closing pause ends |

## Verification
Two events can land in the same cycle: the end-of-frame update of the shared timestamp, and acceptance of a new start. Done is high in the first idle cycle, so a start raised in exactly that cycle is accepted. In that cycle the timestamp update and the quiet-interval decision happen together. The bench polls done just after the clock edge and raises start in that same cycle. It then checks two things: the carrier-on interval before the new frame's first pause is exactly 330 cycles, and the new frame decodes correctly.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_PAUSE,
    ST_MARK,
    ST_CLOSE
  } seq_state_e;

endpackage

// File: rtl/pwtx_timebase.sv
module pwtx_timebase #(
  parameter int TS_W      = 16,
  parameter int GAP_TICKS = 330
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_i,
  input  logic            end_i,
  input  logic [TS_W-1:0] end_stamp_i,
  output logic [TS_W-1:0] now_o,
  output logic [TS_W-1:0] last_end_o,
  output logic            gap_ok_o
);

  localparam logic [TS_W-1:0] GAP_T = TS_W'(GAP_TICKS);

  logic [TS_W-1:0] now_q, now_d;
  logic [TS_W-1:0] last_end_q, last_end_d;
  logic            gap_met_q, gap_met_d;
  logic [TS_W-1:0] elapsed;
  logic            elapsed_ok;

  assign elapsed    = now_q - last_end_q;
  assign elapsed_ok = (elapsed >= GAP_T);

  always_comb begin
    now_d      = now_q + TS_W'(1);
    last_end_d = last_end_q;
    gap_met_d  = gap_met_q;
    if (end_i) begin
      last_end_d = end_stamp_i;
      gap_met_d  = 1'b0;
    end else if (idle_i && elapsed_ok) begin
      gap_met_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q      <= '0;
      last_end_q <= '0;
      gap_met_q  <= 1'b0;
    end else begin
      now_q      <= now_d;
      last_end_q <= last_end_d;
      gap_met_q  <= gap_met_d;
    end
  end

  assign now_o      = now_q;
  assign last_end_o = last_end_q;
  assign gap_ok_o   = gap_met_q | elapsed_ok;

  // Right after a frame end, the quiet interval has not elapsed yet.
  assert_gap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> !gap_met_q);

endmodule

// File: rtl/pwtx_serializer.sv
module pwtx_serializer #(
  parameter int MAX_BITS = 32,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] frame_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                take_i,
  input  logic                ks_bit_i,
  output logic                bit_o,
  output logic                empty_o,
  output logic                ks_adv_o
);

  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BITS);

  logic [MAX_BITS-1:0] shreg_q, shreg_d;
  logic [LEN_W-1:0]    remain_q, remain_d;
  logic                adv_q, adv_d;

  always_comb begin
    shreg_d  = shreg_q;
    remain_d = remain_q;
    adv_d    = take_i;
    if (load_i) begin
      shreg_d  = frame_i;
      remain_d = (len_i > MAX_LEN) ? MAX_LEN : len_i;
    end else if (take_i) begin
      shreg_d  = {1'b0, shreg_q[MAX_BITS-1:1]};
      remain_d = remain_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      remain_q <= '0;
      adv_q    <= 1'b0;
    end else begin
      shreg_q  <= shreg_d;
      remain_q <= remain_d;
      adv_q    <= adv_d;
    end
  end

  // LSB first, whitened with the live keystream bit
  assign bit_o    = shreg_q[0] ^ ks_bit_i;
  assign empty_o  = (remain_q == '0);
  assign ks_adv_o = adv_q;

  assert_take_has_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !empty_o);

  assert_adv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ks_adv_o |=> !ks_adv_o);

endmodule

// File: rtl/pwtx_sequencer.sv
module pwtx_sequencer
  import pwtx_pkg::*;
#(
  parameter int TS_W        = 16,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int GAP_TICKS   = 330
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [TS_W-1:0] now_i,
  input  logic [TS_W-1:0] last_end_i,
  input  logic            gap_ok_i,
  input  logic            empty_i,
  input  logic            bit_i,
  output logic            load_o,
  output logic            take_o,
  output logic            end_o,
  output logic [TS_W-1:0] end_stamp_o,
  output logic            mod_o,
  output logic            busy_o,
  output logic            done_o
);

  localparam logic [TS_W-1:0] PAUSE_T = TS_W'(PAUSE_TICKS);
  localparam logic [TS_W-1:0] ONE_T   = TS_W'(ONE_TICKS - PAUSE_TICKS);
  localparam logic [TS_W-1:0] ZERO_T  = TS_W'(ZERO_TICKS - PAUSE_TICKS);
  localparam logic [TS_W-1:0] GAP_T   = TS_W'(GAP_TICKS);

  seq_state_e      state_q, state_d;
  logic [TS_W-1:0] dl_q, dl_d;
  logic            cur_bit_q, cur_bit_d;
  logic            done_q, done_d;
  logic            hit;

  assign hit = (now_i == dl_q);

  always_comb begin
    state_d   = state_q;
    dl_d      = dl_q;
    cur_bit_d = cur_bit_q;
    done_d    = 1'b0;
    load_o    = 1'b0;
    take_o    = 1'b0;
    end_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_GAP;
          dl_d    = gap_ok_i ? (now_i + TS_W'(1)) : (last_end_i + GAP_T);
        end
      end
      ST_GAP, ST_MARK: begin
        if (hit) begin
          dl_d = dl_q + PAUSE_T;
          if (empty_i) begin
            state_d = ST_CLOSE;
          end else begin
            state_d   = ST_PAUSE;
            take_o    = 1'b1;
            cur_bit_d = bit_i;
          end
        end
      end
      ST_PAUSE: begin
        if (hit) begin
          state_d = ST_MARK;
          dl_d    = dl_q + (cur_bit_q ? ONE_T : ZERO_T);
        end
      end
      ST_CLOSE: begin
        if (hit) begin
          state_d = ST_IDLE;
          end_o   = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dl_q      <= '0;
      cur_bit_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      dl_q      <= dl_d;
      cur_bit_q <= cur_bit_d;
      done_q    <= done_d;
    end
  end

  assign end_stamp_o = dl_q;
  assign mod_o       = (state_q == ST_PAUSE) || (state_q == ST_CLOSE);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  // Phase-length counter used only by the checks below
  logic [TS_W-1:0] ph_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_cnt_q <= '0;
    else if (state_d != state_q) ph_cnt_q <= '0;
    else ph_cnt_q <= ph_cnt_q + TS_W'(1);
  end

  assert_idle_carrier_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mod_o);

  assert_pause_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_PAUSE && state_q == ST_MARK) |->
      $past(ph_cnt_q) == PAUSE_T - TS_W'(1));

  assert_mark_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_MARK && state_q != ST_MARK) |->
      $past(ph_cnt_q) == ($past(cur_bit_q) ? ONE_T : ZERO_T) - TS_W'(1));

  assert_close_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(state_q) == ST_CLOSE && $past(ph_cnt_q) == PAUSE_T - TS_W'(1)));

  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/pause_width_tx.sv
module pause_width_tx #(
  parameter int MAX_BITS    = 32,
  parameter int TS_W        = 16,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 150,
  parameter int ZERO_TICKS  = 90,
  parameter int GAP_TICKS   = 330,
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] frame_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                ks_bit_i,
  output logic                ks_adv_o,
  output logic                mod_o,
  output logic                busy_o,
  output logic                done_o
);

  // Asynchronous assert, synchronous release
  logic rst_meta_n, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sn     <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sn     <= rst_meta_n;
    end
  end

  logic [TS_W-1:0] now, last_end, end_stamp;
  logic            gap_ok, end_evt, load, take, empty, wbit;

  pwtx_timebase #(
    .TS_W      (TS_W),
    .GAP_TICKS (GAP_TICKS)
  ) u_timebase (
    .clk         (clk),
    .rst_n       (rst_sn),
    .idle_i      (!busy_o),
    .end_i       (end_evt),
    .end_stamp_i (end_stamp),
    .now_o       (now),
    .last_end_o  (last_end),
    .gap_ok_o    (gap_ok)
  );

  pwtx_serializer #(
    .MAX_BITS (MAX_BITS)
  ) u_serializer (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load_i   (load),
    .frame_i  (frame_i),
    .len_i    (len_i),
    .take_i   (take),
    .ks_bit_i (ks_bit_i),
    .bit_o    (wbit),
    .empty_o  (empty),
    .ks_adv_o (ks_adv_o)
  );

  pwtx_sequencer #(
    .TS_W        (TS_W),
    .PAUSE_TICKS (PAUSE_TICKS),
    .ONE_TICKS   (ONE_TICKS),
    .ZERO_TICKS  (ZERO_TICKS),
    .GAP_TICKS   (GAP_TICKS)
  ) u_sequencer (
    .clk         (clk),
    .rst_n       (rst_sn),
    .start_i     (start_i),
    .now_i       (now),
    .last_end_i  (last_end),
    .gap_ok_i    (gap_ok),
    .empty_i     (empty),
    .bit_i       (wbit),
    .load_o      (load),
    .take_o      (take),
    .end_o       (end_evt),
    .end_stamp_o (end_stamp),
    .mod_o       (mod_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  assert_adv_in_pause_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    ks_adv_o |-> (mod_o && busy_o));

endmodule

// File: tb/pause_width_tx_tb_top.sv
`timescale 1ns/1ps
module pause_width_tx_tb_top;

  localparam int PAUSE = 30, ONE = 150, ZERO = 90, GAP = 330;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] frame_i;
  logic [5:0]  len_i;
  logic        ks_bit_i;
  logic        ks_adv_o, mod_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  pause_width_tx dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .frame_i  (frame_i),
    .len_i    (len_i),
    .ks_bit_i (ks_bit_i),
    .ks_adv_o (ks_adv_o),
    .mod_o    (mod_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Air monitor, sampled at the falling edge
  int        rise [64];
  int        fall [64];
  int        nr = 0, nf = 0, done_cnt = 0, done_cyc = 0, adv_cnt = 0, ks_pos = 0;
  logic [63:0] ks_pat = '0;
  logic      prev_mod = 1'b0;

  always @(negedge clk) begin
    if (mod_o && !prev_mod && nr < 64) begin rise[nr] = cyc; nr++; end
    if (!mod_o && prev_mod && nf < 64) begin fall[nf] = cyc; nf++; end
    prev_mod = mod_o;
    if (done_o) begin done_cnt++; done_cyc = cyc; end
    if (ks_adv_o) begin adv_cnt++; if (ks_pos < 63) ks_pos++; end
    ks_bit_i = ks_pat[ks_pos];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon_clear(input logic [63:0] ks);
    nr = 0; nf = 0; done_cnt = 0; adv_cnt = 0; ks_pos = 0;
    ks_pat = ks;
  endtask

  task automatic launch(input logic [31:0] f, input int len, input logic [63:0] ks,
                        output int scyc);
    @(posedge clk); #1;
    mon_clear(ks);
    frame_i = f; len_i = 6'(len); start_i = 1'b1; scyc = cyc;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic await_done();
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(posedge clk);
    repeat (2) @(posedge clk);
    check(done_cnt > 0, "R7 done seen", done_cnt, 1);
  endtask

  task automatic verify(input logic [31:0] f, input int len, input logic [63:0] ks,
                        input string tag);
    int eff = (len > 32) ? 32 : len;
    check(nr == eff + 1, {tag, " pause count"}, nr, eff + 1);
    for (int k = 0; k < nr && k < nf; k++)
      check(fall[k] - rise[k] == PAUSE, "R2 pause width", fall[k] - rise[k], PAUSE);
    for (int k = 0; k < eff && k + 1 < nr; k++) begin
      int exp = (f[k] ^ ks[k]) ? ONE : ZERO;
      check(rise[k+1] - rise[k] == exp, {tag, " R3 bit period"}, rise[k+1] - rise[k], exp);
    end
    if (nf > 0) check(done_cyc == fall[nf-1], "R7 done after closing pause", done_cyc, fall[nf-1]);
    check(done_cnt == 1, "R7 done single pulse", done_cnt, 1);
    check(adv_cnt == eff, "R6 keystream advances", adv_cnt, eff);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; frame_i = '0; len_i = '0;
    repeat (4) @(posedge clk);
    #1;
    check(mod_o == 1'b0, "R1 mod in reset", mod_o, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check({mod_o, busy_o, done_o, ks_adv_o} == 4'b0, "R1 outputs after reset",
          {mod_o, busy_o, done_o, ks_adv_o}, 0);
  endtask

  task automatic t_lsb_first();
    int s;
    launch(32'h0000_0001, 8, 64'h0, s);
    await_done();
    verify(32'h0000_0001, 8, 64'h0, "R5 lsb first");
  endtask

  task automatic t_whiten();
    int s;
    launch(32'h0000_A5C3, 16, 64'h0000_0000_0000_3C96, s);
    await_done();
    verify(32'h0000_A5C3, 16, 64'h0000_0000_0000_3C96, "R6 whitening");
  endtask

  task automatic t_gap_elapsed();
    int s;
    repeat (600) @(posedge clk);
    launch(32'h0000_0036, 6, 64'h0, s);
    await_done();
    check(nr > 0 && rise[0] == s + 2, "R11 immediate start", rise[0], s + 2);
    verify(32'h0000_0036, 6, 64'h0, "R11 frame");
  endtask

  task automatic t_back_to_back();
    int s, pf;
    launch(32'h0000_0019, 6, 64'h2A, s);
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk); #1;
      if (done_o) break;
    end
    // start raised in the done cycle itself
    frame_i = 32'h0000_0239; len_i = 6'd11; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    verify(32'h0000_0019, 6, 64'h2A, "R4 first frame");
    pf = (nf > 0) ? fall[nf-1] : 0;
    mon_clear(64'h5C3);
    await_done();
    check(nr > 0 && rise[0] - pf == GAP, "R4 quiet interval", rise[0] - pf, GAP);
    verify(32'h0000_0239, 11, 64'h5C3, "R4 second frame");
  endtask

  task automatic t_len_zero();
    int s;
    launch(32'hFFFF_FFFF, 0, 64'h0, s);
    await_done();
    verify(32'hFFFF_FFFF, 0, 64'h0, "R9 zero length");
  endtask

  task automatic t_len_max();
    int s;
    launch(32'hFFFF_FFFF, 32, 64'h0, s);
    await_done();
    verify(32'hFFFF_FFFF, 32, 64'h0, "R10 full length");
  endtask

  task automatic t_clamp();
    int s;
    launch(32'h8000_0001, 40, 64'h0000_0000_1234_5678, s);
    await_done();
    verify(32'h8000_0001, 40, 64'h0000_0000_1234_5678, "R10 clamped length");
  endtask

  task automatic t_busy_ignore();
    int s, n_before;
    launch(32'h0000_00B4, 8, 64'h0, s);
    repeat (100) @(posedge clk);
    #1;
    frame_i = 32'hFFFF_FFFF; len_i = 6'd20; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    await_done();
    verify(32'h0000_00B4, 8, 64'h0, "R8 busy start");
    n_before = nr;
    repeat (500) @(posedge clk);
    #1;
    check(nr == n_before && !busy_o, "R8 no second frame", nr, n_before);
    check(done_cnt == 1, "R8 done count", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lsb_first();
    t_whiten();
    t_back_to_back();
    t_gap_elapsed();
    t_len_zero();
    t_len_max();
    t_clamp();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule